// File: doc/BRIEF.md
# Multiplexed DRAM Address and Refresh Controller

This controller links a host that issues single-bit read and write requests, each with a 20-bit flat address, to a 1M x 1 dynamic memory whose address pins are shared between a row phase and a column phase. Every host access runs through two phases. First the row strobe goes low while the shared bus carries the row phase value. Then the column strobe goes low while the bus carries the column phase value. The split is uneven. In the row phase the bus carries address bits 9..0. The memory takes bits 8..0 as the row and holds bit 9 for its column latch. In the column phase the bus carries bits 19..10.

Stored charge leaks away, so the controller also runs refresh. An internal timer raises a refresh request at a fixed spacing. Each request produces one cycle in which only the row strobe goes low. That cycle is addressed by a row counter that steps through all 512 rows. A pending refresh wins over a new host request. It never cuts short an access that has already started. The host uses a ready/valid handshake, and ready stays low while a refresh waits or any cycle is in progress.

The sequencer has five states:
- `ST_IDLE`: waiting.
- `ST_ROW`: row strobe low, row phase address on the bus.
- `ST_COL`: both strobes low, column phase address on the bus.
- `ST_REF`: row strobe only, refresh row on the bus.
- `ST_PRE`: both strobes high.

Its transitions are:
- `ST_IDLE` to `ST_REF` when a refresh is pending.
- `ST_IDLE` to `ST_ROW` when a request is accepted.
- `ST_ROW` to `ST_COL` after `T_RAH` clocks.
- `ST_COL` to `ST_PRE` after `T_CAS` clocks.
- `ST_REF` to `ST_PRE` after `T_REF` clocks.
- `ST_PRE` to `ST_IDLE` after `T_PRE` clocks.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high and `rsp_valid` is low. `req_ready` is low during reset and high once reset is released.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. From the next cycle, `dram_ras_n` is low and `dram_addr` equals `req_addr[9:0]`: bits 8..0 form the row and bit 9 goes to the memory's column latch.
- R3: `dram_cas_n` is never low while `dram_ras_n` is high. In an access it falls exactly `T_RAH` cycles after `dram_ras_n` falls.
- R4: While `dram_cas_n` is low, `dram_addr` equals `req_addr[19:10]` and does not change. The column strobe stays low for `T_CAS` cycles. Then both strobes return high in the same cycle.
- R5: Between the rise of `dram_ras_n` and its next fall there are at least `T_PRE` cycles with both strobes high.
- R6: For a write (`req_write`=1), `dram_we_n` is low and `dram_din` holds `req_wdata` whenever the column strobe is low. For a read, `dram_we_n` stays high.
- R7: For a read, `rsp_valid` is high for exactly one cycle, in the cycle the strobes return high. `rsp_rdata` then carries `dram_dout` as it stood in the last column cycle. Writes produce no response.
- R8: Counting clock edges after reset release from 1, a refresh request is raised on every edge whose count is a multiple of `REF_GAP`. No refresh cycle runs without a request.
- R9: A refresh cycle holds `dram_ras_n` low for `T_REF` cycles and keeps `dram_cas_n` high. `dram_addr` equals the zero-extended row counter. The counter starts at 0 and steps by one after each refresh, wrapping from 511 to 0.
- R10: `req_ready` is low while a refresh request is pending or any cycle is running. A pending request starts within `T_RAH+T_CAS+T_PRE+2` cycles, and an access under way always runs to completion.
- R11: Every row is refreshed at least once in every window of `REF_GAP*512` cycles plus one access length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Flat word address |
| req_wdata | input | 1 | Write data bit |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 1 | Read data bit |
| dram_addr | output | 10 | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low, also the chip enable |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | 1 | Data to memory |
| dram_dout | input | 1 | Data from memory |

## Verification
A refresh request from the timer and a host request can arrive on the same clock edge. A refresh request can also fall due in the middle of a host access. The bench provokes both cases by keeping `req_valid` high back to back for long stretches while the refresh spacing is short, so the refresh ticks land at every phase of an access. The outcome is judged at the pins:
- Ready must never be high while the bench's own tick model shows a request pending.
- The access under way must keep its full column width, and both strobes must rise together.
- The refresh that follows must carry the next expected row and start within the latency bound.
- A per-row timestamp table confirms that no row exceeds its refresh window.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_PRE,
        ST_REF
    } seq_state_e;

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int REF_GAP = 1562,
    parameter int ROW_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_taken,
    input  logic             ref_done,
    output logic             ref_pending,
    output logic [ROW_W-1:0] ref_row
);
    localparam int GAP_W = (REF_GAP > 2) ? $clog2(REF_GAP) : 1;

    logic [GAP_W-1:0] gap_cnt;
    logic             tick;

    assign tick = (gap_cnt == GAP_W'(REF_GAP - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt     <= '0;
            ref_pending <= 1'b0;
            ref_row     <= '0;
        end else begin
            gap_cnt     <= tick ? '0 : gap_cnt + 1'b1;
            ref_pending <= tick | (ref_pending & ~ref_taken);
            if (ref_done) begin
                ref_row <= ref_row + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_mux_pkg::*;
#(
    parameter int T_RAH = 2,
    parameter int T_CAS = 2,
    parameter int T_PRE = 3,
    parameter int T_REF = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_acc,
    input  logic       start_ref,
    output seq_state_e state_o,
    output logic       last_o
);
    localparam int T_M1  = (T_RAH > T_CAS) ? T_RAH : T_CAS;
    localparam int T_M2  = (T_PRE > T_REF) ? T_PRE : T_REF;
    localparam int T_MAX = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int CNT_W = $clog2(T_MAX + 1);

    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len;

    always_comb begin
        unique case (st_q)
            ST_ROW:  len = CNT_W'(T_RAH);
            ST_COL:  len = CNT_W'(T_CAS);
            ST_PRE:  len = CNT_W'(T_PRE);
            ST_REF:  len = CNT_W'(T_REF);
            default: len = CNT_W'(1);
        endcase
    end

    assign last_o = (cnt_q == len - 1'b1);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_ref) st_d = ST_REF;
                else if (start_acc) st_d = ST_ROW;
            end
            ST_ROW: if (last_o) st_d = ST_COL;
            ST_COL: if (last_o) st_d = ST_PRE;
            ST_REF: if (last_o) st_d = ST_PRE;
            ST_PRE: if (last_o) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= (st_d != st_q) ? '0 : cnt_q + 1'b1;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_mux_pkg::*;
#(
    parameter int MUX_W = 10,
    parameter int ROW_W = 9
) (
    input  seq_state_e       state,
    input  logic [MUX_W-1:0] row_part,
    input  logic [MUX_W-1:0] col_part,
    input  logic [ROW_W-1:0] ref_row,
    output logic [MUX_W-1:0] mux_addr
);
    logic [MUX_W-1:0] ref_ext;

    generate
        if (MUX_W > ROW_W) begin : g_pad
            assign ref_ext = {{(MUX_W - ROW_W){1'b0}}, ref_row};
        end else begin : g_nopad
            assign ref_ext = ref_row[MUX_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (state)
            ST_COL:  mux_addr = col_part;
            ST_REF:  mux_addr = ref_ext;
            default: mux_addr = row_part;
        endcase
    end

endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
    import dram_mux_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int MUX_W   = 10,
    parameter int ROW_W   = 9,
    parameter int REF_GAP = 1562,
    parameter int T_RAH   = 2,
    parameter int T_CAS   = 2,
    parameter int T_PRE   = 3,
    parameter int T_REF   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    output logic              rsp_valid,
    output logic              rsp_rdata,
    output logic [MUX_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_din,
    input  logic              dram_dout
);
    localparam int COL_W = ADDR_W - MUX_W;

    seq_state_e        state;
    logic              last;
    logic              ref_pending;
    logic [ROW_W-1:0]  ref_row;
    logic              start_acc, start_ref, ref_done;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q, wd_q;
    logic [MUX_W-1:0]  col_part;

    assign start_ref = (state == ST_IDLE) && ref_pending;
    assign start_acc = req_valid && req_ready;
    assign ref_done  = (state == ST_REF) && last;
    assign req_ready = rst_n && (state == ST_IDLE) && !ref_pending;

    dram_refresh_timer #(.REF_GAP(REF_GAP), .ROW_W(ROW_W)) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_taken   (start_ref),
        .ref_done    (ref_done),
        .ref_pending (ref_pending),
        .ref_row     (ref_row)
    );

    dram_seq_fsm #(.T_RAH(T_RAH), .T_CAS(T_CAS), .T_PRE(T_PRE), .T_REF(T_REF)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .start_ref (start_ref),
        .state_o   (state),
        .last_o    (last)
    );

    assign col_part = MUX_W'(addr_q[ADDR_W-1:MUX_W]);

    dram_addr_mux #(.MUX_W(MUX_W), .ROW_W(ROW_W)) mux_i (
        .state    (state),
        .row_part (addr_q[MUX_W-1:0]),
        .col_part (col_part),
        .ref_row  (ref_row),
        .mux_addr (dram_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wr_q      <= 1'b0;
            wd_q      <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= 1'b0;
        end else begin
            if (start_acc) begin
                addr_q <= req_addr;
                wr_q   <= req_write;
                wd_q   <= req_wdata;
            end
            rsp_valid <= (state == ST_COL) && last && !wr_q;
            if ((state == ST_COL) && last) begin
                rsp_rdata <= dram_dout;
            end
        end
    end

    always_comb begin
        dram_ras_n = 1'b1;
        dram_cas_n = 1'b1;
        dram_we_n  = 1'b1;
        unique case (state)
            ST_ROW: dram_ras_n = 1'b0;
            ST_REF: dram_ras_n = 1'b0;
            ST_COL: begin
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
                dram_we_n  = ~wr_q;
            end
            default: ;
        endcase
    end

    assign dram_din = wd_q;

    if (COL_W != MUX_W) begin : g_bad_split
        initial $error("column width must equal mux width");
    end

endmodule

// File: rtl/dram_mux_chk.sv
module dram_mux_chk #(
    parameter int MUX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic [MUX_W-1:0] addr,
    input logic             ready,
    input logic             rsp_valid
);
    // R3: column strobe only while row strobe is active
    a_r3_cas_needs_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // R3: column strobe falls only after a row-strobe cycle
    a_r3_row_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(!ras_n));

    // R4: strobes release together
    a_r4_release_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> ras_n);

    // R4: column address held steady
    a_r4_col_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && $past(!cas_n)) |-> $stable(addr));

    // R10: no acceptance during an active strobe
    a_r10_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !ready);

    // R7: response is a single-cycle pulse
    a_r7_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind dram_mux_ctrl dram_mux_chk #(.MUX_W(MUX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .addr      (dram_addr),
    .ready     (req_ready),
    .rsp_valid (rsp_valid)
);

// File: tb/dram_mux_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_mux_ctrl_tb_top;
    localparam int GAP   = 24;
    localparam int T_RAH = 2;
    localparam int T_CAS = 2;
    localparam int T_PRE = 3;
    localparam int T_REF = 3;
    localparam int ROWS  = 512;
    localparam int LAT   = T_RAH + T_CAS + T_PRE + 2;
    localparam int DEADLINE = GAP * ROWS + 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_wdata = 1'b0;
    logic        rsp_valid, rsp_rdata;
    logic [9:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_din;
    logic        dram_dout = 1'b0;

    always #2.5 clk = ~clk;

    dram_mux_ctrl #(.REF_GAP(GAP), .T_RAH(T_RAH), .T_CAS(T_CAS),
                    .T_PRE(T_PRE), .T_REF(T_REF)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_din(dram_din), .dram_dout(dram_dout)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural models
    bit          mem[int];
    bit          shadow[int];
    logic [19:0] acc_a_q[$];
    bit          acc_w_q[$];
    bit          acc_d_q[$];
    bit          exp_rd_q[$];

    int  edges = 0;
    always @(posedge clk) if (rst_n) edges++;

    bit          prev_ras = 1, prev_cas = 1, monitor_on = 0;
    int          hi_cnt = 100, lo_cnt = 0, cas_cnt = 0;
    bit          cur_ref = 0, cur_wr = 0, cas_seen = 0, rsp_due;
    logic [19:0] cur_a = '0;
    logic [8:0]  lat_row = '0;
    bit          lat_b9 = 0;
    bit          bench_pend = 0;
    int          pend_age = 0, ticks = 0, refs = 0;
    int          exp_row = 0;
    int          last_ref[ROWS];
    int          last_tick_seen = 0;

    initial for (int r = 0; r < ROWS; r++) last_ref[r] = 0;

    always @(negedge clk) if (monitor_on) begin
        rsp_due = 0;
        if (edges != last_tick_seen && edges % GAP == 0) begin
            bench_pend = 1; pend_age = 0; ticks++;
        end
        last_tick_seen = edges;
        if (bench_pend) pend_age++;
        // R10: priority of a pending refresh over the host
        if (req_ready && (bench_pend || !dram_ras_n))
            chk(0, "R10 ready while refresh pending or busy", req_ready, 0);
        if (pend_age > LAT)
            chk(0, "R10 refresh start latency", pend_age, LAT);
        // R3: column strobe without row strobe
        if (!dram_cas_n && dram_ras_n) chk(0, "R3 cas without ras", dram_cas_n, 1);

        if (prev_ras && !dram_ras_n) begin
            chk(hi_cnt >= T_PRE, "R5 precharge gap", hi_cnt, T_PRE);
            lo_cnt = 0; cas_cnt = 0; cas_seen = 0;
            lat_row = dram_addr[8:0]; lat_b9 = dram_addr[9];
            if (acc_a_q.size() > 0) begin
                cur_ref = 0; cur_a = acc_a_q[0]; cur_wr = acc_w_q[0];
                chk(dram_addr == cur_a[9:0], "R2 row phase address", dram_addr, cur_a[9:0]);
            end else begin
                cur_ref = 1;
                chk(bench_pend, "R8 refresh without request", 0, 1);
                chk(dram_addr == 10'(exp_row), "R9 refresh row", dram_addr, exp_row);
                last_ref[exp_row] = edges;
                exp_row = (exp_row + 1) % ROWS;
                refs++;
                bench_pend = 0; pend_age = 0;
            end
        end
        if (!dram_ras_n) lo_cnt++;
        if (prev_cas && !dram_cas_n) begin
            cas_seen = 1;
            chk(!cur_ref && lo_cnt == T_RAH + 1, "R3 row-to-column delay", lo_cnt - 1, T_RAH);
            chk(dram_addr == cur_a[19:10], "R4 column phase address", dram_addr, cur_a[19:10]);
            chk(dram_we_n == !cur_wr, "R6 write enable level", dram_we_n, !cur_wr);
            begin
                int fa;
                fa = int'({dram_addr, lat_b9, lat_row});
                if (!dram_we_n) begin
                    chk(dram_din == acc_d_q[0], "R6 write data", dram_din, acc_d_q[0]);
                    mem[fa] = dram_din;
                end
                dram_dout = mem.exists(fa) ? mem[fa] : 1'b0;
            end
        end
        if (!dram_cas_n) cas_cnt++;
        if (!prev_ras && dram_ras_n) begin
            hi_cnt = 0;
            if (cur_ref) begin
                chk(lo_cnt == T_REF && !cas_seen, "R9 refresh strobe shape", lo_cnt, T_REF);
            end else begin
                chk(!prev_cas && dram_cas_n && cas_cnt == T_CAS,
                    "R4 column width and joint release", cas_cnt, T_CAS);
                if (!cur_wr) rsp_due = 1;
                void'(acc_a_q.pop_front()); void'(acc_w_q.pop_front()); void'(acc_d_q.pop_front());
            end
        end
        if (dram_ras_n) hi_cnt++;
        // R7: response timing and data
        if (rsp_valid != rsp_due) chk(0, "R7 response timing", rsp_valid, rsp_due);
        if (rsp_valid && exp_rd_q.size() > 0) begin
            bit e;
            e = exp_rd_q.pop_front();
            chk(rsp_rdata == e, "R7 read data", rsp_rdata, e);
        end
        // R11: refresh deadline per row
        if (edges % 256 == 0) begin
            for (int r = 0; r < ROWS; r++)
                if (edges - last_ref[r] > DEADLINE)
                    chk(0, "R11 row refresh deadline", edges - last_ref[r], DEADLINE);
        end
        prev_ras = dram_ras_n; prev_cas = dram_cas_n;
    end

    task automatic do_req(input bit wr, input logic [19:0] a, input bit d);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        acc_a_q.push_back(a); acc_w_q.push_back(wr); acc_d_q.push_back(d);
        if (wr) shadow[int'(a)] = d;
        else exp_rd_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 1'b0);
        @(negedge clk);
        req_valid = 0;
    endtask

    logic [19:0] pool[16];

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle in reset", {dram_ras_n, dram_cas_n}, 3);
        chk(!req_ready && !rsp_valid, "R1 ready and response low in reset", req_ready, 0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
        chk(dram_ras_n && dram_cas_n && !rsp_valid, "R1 idle after reset", dram_ras_n, 1);
        monitor_on = 1;

        // directed corners of the address split (R2, R4, R6, R7)
        do_req(1, 20'h00000, 1);
        do_req(1, 20'hFFFFF, 1);
        do_req(1, 20'h00200, 1);
        do_req(1, 20'h001FF, 0);
        do_req(1, 20'hFFC00, 1);
        do_req(0, 20'h00000, 0);
        do_req(0, 20'hFFFFF, 0);
        do_req(0, 20'h00200, 0);
        do_req(0, 20'h001FF, 0);
        do_req(0, 20'hFFC00, 0);
        do_req(0, 20'h00201, 0);

        // mixed traffic, back to back, colliding with refresh ticks (R10)
        for (int i = 0; i < 16; i++) pool[i] = 20'($urandom);
        for (int i = 0; i < 600; i++) begin
            int g;
            do_req(1'($urandom), pool[$urandom % 16], 1'($urandom));
            g = ($urandom % 4 == 0) ? int'($urandom % 6) : 0;
            repeat (g) @(negedge clk);
        end
        // idle long enough for a full row wrap and deadlines (R9, R11)
        repeat (GAP * ROWS + 200) @(negedge clk);
        chk(refs >= ROWS + 1, "R9 row counter wrapped", refs, ROWS + 1);
        chk(ticks - refs <= 1 && refs <= ticks, "R8 refresh count matches ticks", refs, ticks);
        chk(exp_rd_q.size() == 0 && acc_a_q.size() == 0, "R7 all responses returned", exp_rd_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", edges, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule